// File: doc/BRIEF.md
# Multi-Queue Almost-Flag Status Bus

This block drives a narrow status bus that carries one almost-flag bit for each of the four queues of a multi-queue device. One instance sits on the read side and reports almost-empty status, clocked by the read clock. A second instance sits on the write side and reports almost-full status, clocked by the write clock. The flags arrive as an active-low vector, one bit per queue, from threshold logic that is outside this block. A flag bit is LOW when its queue has crossed its almost threshold. The threshold arithmetic and the queue storage are out of scope.

Several devices may share one status bus, each with its own 3-bit device ID. A mode input is sampled while master reset is held and then stays fixed. In direct mode, a strobe together with a device address selects which device owns the bus. The selected device then shows its own live flags, one clock late, until a later strobe names a different device. In polled mode, a free-running slot counter steps through all eight device IDs, one per clock. The device whose ID matches the current slot drives the bus, and a sync pulse marks slot 0. This block does not contain the tri-state pad. It gives a drive enable for the pad, and it holds the data lines at the inactive level (all ones) whenever it does not own the bus.

Top module: `qflag_bus`

## Requirements
- R1: `mode_sel_i` is captured on every clock edge where `rst` is high (1 = polled, 0 = direct). After `rst` falls, changes on `mode_sel_i` do not affect the outputs.
- R2: While `rst` is high, and in the first cycle after it, `bus_en_o` = 0, `sync_o` = 0 and `bus_o` = 4'b1111.
- R3: In direct mode, a clock edge with `strobe_i` = 1 and `addr_i` == `dev_id_i` sets `bus_en_o` = 1 from the next cycle.
- R4: While this device owns the bus, `bus_o` equals `flag_n_i` as sampled at the previous clock edge. Bit q carries queue q, and a bit is 0 when that queue is almost-empty or almost-full.
- R5: In direct mode, a clock edge with `strobe_i` = 1 and `addr_i` != `dev_id_i` clears `bus_en_o` from the next cycle. With `strobe_i` = 0, ownership does not change.
- R6: In polled mode, a slot counter starts at 0 on the first edge after reset is released. It advances by one each clock and wraps from 7 to 0, so the pattern repeats every 8 cycles.
- R7: In polled mode, `sync_o` is high for exactly the one cycle of slot 0 in each scan.
- R8: In polled mode, `bus_en_o` is high only in the slot equal to `dev_id_i`. In every other slot, `bus_en_o` = 0 and `bus_o` = 4'b1111.
- R9: In polled mode, `strobe_i` and `addr_i` have no effect on any output.
- R10: In direct mode, `sync_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Read clock (empty side) or write clock (full side) |
| rst | input | 1 | Synchronous active-high master reset |
| mode_sel_i | input | 1 | Flag mode, sampled during reset: 1 polled, 0 direct |
| dev_id_i | input | 3 | This device's ID, held static |
| flag_n_i | input | 4 | Live active-low almost-flags, one bit per queue |
| strobe_i | input | 1 | Direct-mode bus selection strobe |
| addr_i | input | 3 | Device address used with the strobe |
| bus_o | output | 4 | Status bus data, all ones when not owned |
| bus_en_o | output | 1 | Drive enable for the tri-state bus pad |
| sync_o | output | 1 | Scan start marker, polled mode only |

## Verification
Some properties are checked on every cycle. The mode stays fixed after reset. `sync_o` never lasts more than one cycle and never appears in direct mode. The data lines sit at all ones whenever the enable is low. Owned data always follows the previous cycle's flags. A matching strobe always takes the bus, and a foreign strobe always releases it. Other behaviour can only be shown by the bench scenarios, run against an independent model: the exact 8-cycle scan phase relative to reset release, the slot in which a given device ID owns the bus, the case where ID 0's ownership coincides with sync, and that strobes have no effect in polled mode.

// File: rtl/qfb_pkg.sv
package qfb_pkg;

    typedef enum logic {
        MODE_DIRECT = 1'b0,
        MODE_POLLED = 1'b1
    } flag_mode_e;

    // Bus ownership control produced by each scheduling scheme.
    typedef struct packed {
        logic drive;
        logic sync;
    } bus_ctl_t;

    localparam bus_ctl_t CTL_IDLE = '{drive: 1'b0, sync: 1'b0};

endpackage

// File: rtl/qfb_mode_latch.sv
module qfb_mode_latch
    import qfb_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       mode_sel_i,
    output flag_mode_e mode_o
);

    flag_mode_e mode_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= flag_mode_e'(mode_sel_i);
        end
    end

    assign mode_o = mode_q;

    AST_MODE_HOLD: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> $stable(mode_q)); // R1

endmodule

// File: rtl/qfb_poll_scan.sv
module qfb_poll_scan
    import qfb_pkg::*;
#(
    parameter int ID_W = 3
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            en_i,
    input  logic [ID_W-1:0] dev_id_i,
    output bus_ctl_t        ctl_o
);

    localparam int              NUM_DEV = 1 << ID_W;
    localparam logic [ID_W-1:0] LAST    = ID_W'(NUM_DEV - 1);

    logic [ID_W-1:0] slot_q;
    logic            active_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_q   <= LAST;
            active_q <= 1'b0;
        end else begin
            active_q <= 1'b1;
            slot_q   <= (slot_q == LAST) ? '0 : slot_q + 1'b1;
        end
    end

    always_comb begin
        ctl_o       = CTL_IDLE;
        ctl_o.drive = en_i && active_q && (slot_q == dev_id_i);
        ctl_o.sync  = en_i && active_q && (slot_q == '0);
    end

    AST_SYNC_SINGLE: assert property (@(posedge clk) disable iff (rst)
        ctl_o.sync |=> !ctl_o.sync); // R7

    AST_SCAN_START: assert property (@(posedge clk) disable iff (rst)
        (active_q && !$past(active_q)) |-> (slot_q == '0)); // R6

    AST_SLOT_MOVES: assert property (@(posedge clk) disable iff (rst)
        (active_q && $past(active_q)) |-> (slot_q != $past(slot_q))); // R6

endmodule

// File: rtl/qfb_direct_sel.sv
module qfb_direct_sel
    import qfb_pkg::*;
#(
    parameter int ID_W = 3
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            en_i,
    input  logic            strobe_i,
    input  logic [ID_W-1:0] addr_i,
    input  logic [ID_W-1:0] dev_id_i,
    output bus_ctl_t        ctl_o
);

    logic sel_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q <= 1'b0;
        end else if (en_i && strobe_i) begin
            sel_q <= (addr_i == dev_id_i);
        end
    end

    always_comb begin
        ctl_o       = CTL_IDLE;
        ctl_o.drive = en_i && sel_q;
    end

    AST_DIR_TAKE: assert property (@(posedge clk) disable iff (rst)
        (en_i && strobe_i && addr_i == dev_id_i) |=> sel_q); // R3

    AST_DIR_RELEASE: assert property (@(posedge clk) disable iff (rst)
        (en_i && strobe_i && addr_i != dev_id_i) |=> !sel_q); // R5

    AST_DIR_HOLD: assert property (@(posedge clk) disable iff (rst)
        !strobe_i |=> $stable(sel_q)); // R5

endmodule

// File: rtl/qflag_bus.sv
module qflag_bus
    import qfb_pkg::*;
#(
    parameter int NUM_Q = 4,
    parameter int ID_W  = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             mode_sel_i,
    input  logic [ID_W-1:0]  dev_id_i,
    input  logic [NUM_Q-1:0] flag_n_i,
    input  logic             strobe_i,
    input  logic [ID_W-1:0]  addr_i,
    output logic [NUM_Q-1:0] bus_o,
    output logic             bus_en_o,
    output logic             sync_o
);

    flag_mode_e       mode;
    logic             polled;
    bus_ctl_t         poll_ctl;
    bus_ctl_t         dir_ctl;
    bus_ctl_t         ctl;
    logic [NUM_Q-1:0] flag_q;

    qfb_mode_latch u_mode (
        .clk        (clk),
        .rst        (rst),
        .mode_sel_i (mode_sel_i),
        .mode_o     (mode)
    );

    assign polled = (mode == MODE_POLLED);

    qfb_poll_scan #(.ID_W(ID_W)) u_scan (
        .clk      (clk),
        .rst      (rst),
        .en_i     (polled),
        .dev_id_i (dev_id_i),
        .ctl_o    (poll_ctl)
    );

    qfb_direct_sel #(.ID_W(ID_W)) u_dsel (
        .clk      (clk),
        .rst      (rst),
        .en_i     (!polled),
        .strobe_i (strobe_i),
        .addr_i   (addr_i),
        .dev_id_i (dev_id_i),
        .ctl_o    (dir_ctl)
    );

    // Flag sample register: bus shows flags one clock late.
    always_ff @(posedge clk) begin
        flag_q <= flag_n_i;
    end

    assign ctl      = polled ? poll_ctl : dir_ctl;
    assign bus_en_o = ctl.drive;
    assign sync_o   = ctl.sync;

    for (genvar q = 0; q < NUM_Q; q++) begin : g_lane
        assign bus_o[q] = ctl.drive ? flag_q[q] : 1'b1;
    end

    AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (rst)
        !bus_en_o |-> (bus_o == '1)); // R8

    AST_DIRECT_NO_SYNC: assert property (@(posedge clk) disable iff (rst)
        !polled |-> !sync_o); // R10

    AST_OWNED_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        bus_en_o |-> (bus_o == $past(flag_n_i))); // R4

    AST_SYNC_OWNER: assert property (@(posedge clk) disable iff (rst)
        (sync_o && bus_en_o) |-> (dev_id_i == '0)); // R8

endmodule

// File: tb/qflag_bus_bench.sv
module qflag_bus_bench;

    localparam int NQ   = 4;
    localparam int IW   = 3;
    localparam int NDEV = 1 << IW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          mode_sel = 1'b0;
    logic [IW-1:0] dev_id = '0;
    logic [NQ-1:0] flag_n = '1;
    logic          strobe = 1'b0;
    logic [IW-1:0] addr = '0;
    logic [NQ-1:0] bus;
    logic          bus_en;
    logic          sync;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // Requirement model state
    bit            m_poll;
    bit            m_sel;
    bit            m_active;
    int            m_slot;
    logic [NQ-1:0] m_flag;
    int            cyc = 0;
    int            last_sync = -1;

    always #2 clk = ~clk;

    qflag_bus u_qflag_bus (
        .clk        (clk),
        .rst        (rst),
        .mode_sel_i (mode_sel),
        .dev_id_i   (dev_id),
        .flag_n_i   (flag_n),
        .strobe_i   (strobe),
        .addr_i     (addr),
        .bus_o      (bus),
        .bus_en_o   (bus_en),
        .sync_o     (sync)
    );

    function automatic bit exp_en();
        if (m_poll) return m_active && (m_slot == int'(dev_id));
        return m_sel;
    endfunction

    function automatic bit exp_sync();
        return m_poll && m_active && (m_slot == 0);
    endfunction

    function automatic logic [NQ-1:0] exp_bus();
        return exp_en() ? m_flag : '1;
    endfunction

    task automatic cmp(string tag, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s cycle %0d: actual %0h expected %0h", tag, cyc, act, exp);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    // One clock: model update on the edge, then compare 1 ns later.
    task automatic step(string phase);
        @(posedge clk);
        cyc++;
        if (rst) begin
            m_poll   = mode_sel;
            m_sel    = 1'b0;
            m_active = 1'b0;
            m_slot   = NDEV - 1;
        end else begin
            m_active = 1'b1;
            m_slot   = (m_slot + 1) % NDEV;
            if (!m_poll && strobe) m_sel = (addr == dev_id);
        end
        m_flag = flag_n;
        #1;
        if (rst) begin
            cmp({phase, " R2 en"},   32'(bus_en), 32'(0));
            cmp({phase, " R2 sync"}, 32'(sync),   32'(0));
            cmp({phase, " R2 bus"},  32'(bus),    32'(4'hF));
        end else if (m_poll) begin
            cmp({phase, " R8 en"},   32'(bus_en), 32'(exp_en()));
            cmp({phase, " R7 sync"}, 32'(sync),   32'(exp_sync()));
            cmp({phase, " R4 bus"},  32'(bus),    32'(exp_bus()));
            if (sync) begin
                if (last_sync >= 0) cmp({phase, " R6 period"}, 32'(cyc - last_sync), 32'(NDEV));
                last_sync = cyc;
            end
        end else begin
            cmp({phase, " R3 en"},    32'(bus_en), 32'(exp_en()));
            cmp({phase, " R10 sync"}, 32'(sync),   32'(0));
            cmp({phase, " R4 bus"},   32'(bus),    32'(exp_bus()));
        end
    endtask

    task automatic do_reset(bit mode, logic [IW-1:0] id);
        rst = 1'b1; mode_sel = mode; dev_id = id; strobe = 1'b0;
        last_sync = -1;
        step("reset");
        step("reset");
        rst = 1'b0;
        step("R2 first");
        cmp("R2 first en after reset", 32'(bus_en), 32'(exp_en()));
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin : main
        int seed;
        seed = $urandom(32'h5eed_0042);
        m_flag = '1;

        // Polled mode, device 5, random strobes must be ignored (R9)
        do_reset(1'b1, 3'd5);
        for (int i = 0; i < 48; i++) begin
            flag_n = NQ'($urandom);
            strobe = $urandom_range(0, 1) == 1;
            addr   = IW'($urandom);
            step("R9 polled");
        end

        // Direct mode, device 3
        do_reset(1'b0, 3'd3);
        cmp("R5 idle before strobe", 32'(bus_en), 32'(0));
        flag_n = 4'b1010; strobe = 1'b1; addr = 3'd3;
        step("R3 take");
        cmp("R3 owned after matching strobe", 32'(bus_en), 32'(1));
        cmp("R4 loaded flags", 32'(bus), 32'(4'b1010));
        strobe = 1'b0;
        for (int i = 0; i < 10; i++) begin
            flag_n = NQ'($urandom);
            step("R4 follow");
        end
        flag_n = 4'b0000; strobe = 1'b1; addr = 3'd6;
        step("R5 release");
        cmp("R5 released by foreign strobe", 32'(bus_en), 32'(0));
        cmp("R5 idle level", 32'(bus), 32'(4'hF));
        strobe = 1'b0;
        for (int i = 0; i < 4; i++) begin
            flag_n = NQ'($urandom);
            step("R5 hold");
        end
        for (int i = 0; i < 80; i++) begin
            flag_n   = NQ'($urandom);
            strobe   = $urandom_range(0, 3) == 0;
            addr     = ($urandom_range(0, 1) == 1) ? 3'd3 : IW'($urandom);
            mode_sel = $urandom_range(0, 1) == 1;
            step("R1 direct random");
        end

        // Polled mode, device 0: ownership coincides with sync; mode input toggles (R1)
        do_reset(1'b1, 3'd0);
        cmp("R8 id0 owns slot0", 32'(bus_en), 32'(1));
        cmp("R7 sync in slot0", 32'(sync), 32'(1));
        for (int i = 0; i < 40; i++) begin
            flag_n   = NQ'($urandom);
            mode_sel = ~mode_sel;
            strobe   = $urandom_range(0, 1) == 1;
            addr     = IW'($urandom);
            step("R1 polled toggle");
        end

        // Polled mode, device 7: last slot before wrap
        do_reset(1'b1, 3'd7);
        for (int i = 0; i < 24; i++) begin
            flag_n = NQ'($urandom);
            step("R6 wrap");
        end

        summary();
    end

endmodule